// File: doc/BRIEF.md
# Pedestal-Tracking Zero-Suppression Filter

This front-end stage sits between several multi-channel readout chips and the data link. During a bunch train it receives one digitised sample per channel per crossing, keeps a running pedestal estimate for every channel, subtracts it, and forwards only samples whose corrected amplitude rises above a programmable threshold. Each forwarded word carries the bunch number, the channel index, the signed corrected amplitude and a flag that marks unsuppressed data.

The pedestal follows slow drift through an exponential moving average that only learns from samples that look like baseline, so real hits do not pull it upward. Because the chips are power-cycled between trains, a programmable number of crossings at the start of each train is used for pedestal learning only. Selected channels, or all channels at once, can be forced into unsuppressed readout to collect raw pedestal data. A small FIFO absorbs short stalls on the output stream; overflow is recorded in a sticky flag and a drop counter.

Top module: `zsup_filter`

## Requirements
- R1: After reset the output stream is idle, every pedestal is 0, and the registers read: control 0x0000_0400 (step shift 4, force-all 0), threshold 20, settling length 8, status 0, channel masks 0.
- R2: Samples are taken only between a train-start pulse and a train-end pulse (a sample in the same cycle as the start pulse is not taken); samples outside a train produce no output and leave pedestals unchanged.
- R3: The bunch number is cleared by train-start and increments by one (modulo 4096) after each taken sample marked as the last of its crossing; every word carries the bunch number of the crossing it belongs to.
- R4: The corrected amplitude is the sample minus the integer part of the channel pedestal, saturated to the 14-bit signed range [-8192, 8191]; outside the settling window a channel not in raw mode is forwarded with raw flag 0 exactly when the amplitude is strictly greater than the threshold.
- R5: The pedestal holds 8 fraction bits and is updated as ped += (sample*256 - ped) >>> k (arithmetic shift), with k taken from control bits [11:8] and clamped to the range 2..8; the update happens when the sample is in the settling window or its amplitude is not above the threshold.
- R6: While fewer than N crossings of the current train have completed (N in the settling register, bits [11:0]), no sample is forwarded by the threshold rule and every taken sample updates its pedestal.
- R7: A channel is in raw mode when control bit 0 (force-all) is set or its mask bit is set (channel c is bit c%32 of mask word at address 8 + c/32); every taken raw-mode sample is forwarded with raw flag 1, including in the settling window.
- R8: Output word layout: bit 34 raw flag, bits 33:22 bunch number, bits 21:14 channel, bits 13:0 corrected amplitude in two's complement.
- R9: Words leave in arrival order; while out_valid is high and out_ready low, out_valid stays high and out_data stays unchanged.
- R10: A word produced while the FIFO (8 entries) is full and not being read is dropped; status bit 31 then becomes set and stays set, status bits 15:0 count drops (saturating at 65535), and any write to the status address (3) clears both.
- R11: Threshold (address 1, bits 12:0), settling length (address 2), control (address 0) and mask words (addresses 8..15) read back what was last written; unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| train_start | input | 1 | Pulse opening a bunch train |
| train_end | input | 1 | Pulse closing a bunch train |
| s_valid | input | 1 | Sample present |
| s_last | input | 1 | Sample is the last one of its crossing |
| s_chan | input | 8 | Channel index of the sample |
| s_adc | input | 14 | Unsigned ADC code |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | 35 | Tagged output word |

## Verification
The bench builds the block with its default parameters: 14-bit samples, 256 channels, a 12-bit bunch number, 8 pedestal fraction bits and an 8-entry FIFO. The small FIFO depth makes overflow reachable with eleven back-to-back samples against a stalled output, and the full 14-bit sample range lets both saturation limits of the corrected amplitude be hit from a pedestal learned during the settling window. Pedestal values reach the ports only through corrected amplitudes, so the bench learns them back through raw-mode words and through the exact threshold boundary.

// File: rtl/zsup_pkg.sv
package zsup_pkg;

   // register word addresses (4-bit address space)
   localparam logic [3:0] A_CTRL   = 4'h0;
   localparam logic [3:0] A_THRESH = 4'h1;
   localparam logic [3:0] A_SETTLE = 4'h2;
   localparam logic [3:0] A_STATUS = 4'h3;
   localparam logic [3:0] A_MASK0  = 4'h8;

   localparam int REG_DW       = 32;
   localparam int MASK_WORD_W  = 32;
   localparam int MAX_MASK_WDS = 8;
   localparam int K_FIELD_W    = 4;
   localparam int CTRL_ALL_BIT = 0;
   localparam int CTRL_K_LSB   = 8;
   localparam int STAT_OVF_BIT = 31;

endpackage

// File: rtl/zsup_cfg_regs.sv
module zsup_cfg_regs
   import zsup_pkg::*;
#(
   parameter int ADC_W      = 14,
   parameter int CH_W       = 8,
   parameter int BX_W       = 12,
   parameter int DROP_W     = 16,
   parameter int K_MIN      = 2,
   parameter int K_MAX      = 8,
   parameter int THR_RST    = 20,
   parameter int K_RST      = 4,
   parameter int SETTLE_RST = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cfg_we,
   input  logic [3:0]                cfg_addr,
   input  logic [REG_DW-1:0]         cfg_wdata,
   output logic [REG_DW-1:0]         cfg_rdata,
   input  logic                      drop_evt,
   output logic                      force_all,
   output logic [K_FIELD_W-1:0]      k_eff,
   output logic [ADC_W-2:0]          thr,
   output logic [BX_W-1:0]           settle_n,
   output logic [(1<<CH_W)-1:0]      chan_mask,
   output logic                      ovf,
   output logic                      status_clr
);
   localparam int NCH   = 1 << CH_W;
   localparam int MW    = NCH / MASK_WORD_W;
   localparam int THR_W = ADC_W - 1;
   localparam logic [K_FIELD_W-1:0] K_LO = K_FIELD_W'(K_MIN);
   localparam logic [K_FIELD_W-1:0] K_HI = K_FIELD_W'(K_MAX);

   if (THR_W > 31) begin : g_bad_thr
      $error("threshold field does not fit a register word");
   end
   if (BX_W > 31 || DROP_W > 31) begin : g_bad_cnt
      $error("counter field does not fit a register word");
   end
   if (MW < 1 || MW > MAX_MASK_WDS) begin : g_bad_mask
      $error("channel count must give 1..8 mask words");
   end
   if (K_MIN > K_MAX || K_MAX >= (1 << K_FIELD_W)) begin : g_bad_k
      $error("shift limits out of range");
   end

   logic                    force_q;
   logic [K_FIELD_W-1:0]    k_q;
   logic [THR_W-1:0]        thr_q;
   logic [BX_W-1:0]         settle_q;
   logic                    ovf_q;
   logic [DROP_W-1:0]       drops_q;
   logic [MASK_WORD_W-1:0]  mask_w [MW];

   assign status_clr = cfg_we && (cfg_addr == A_STATUS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         force_q  <= 1'b0;
         k_q      <= K_FIELD_W'(K_RST);
         thr_q    <= THR_W'(THR_RST);
         settle_q <= BX_W'(SETTLE_RST);
      end else if (cfg_we) begin
         case (cfg_addr)
            A_CTRL: begin
               force_q <= cfg_wdata[CTRL_ALL_BIT];
               k_q     <= cfg_wdata[CTRL_K_LSB +: K_FIELD_W];
            end
            A_THRESH: thr_q    <= cfg_wdata[THR_W-1:0];
            A_SETTLE: settle_q <= cfg_wdata[BX_W-1:0];
            default: ;
         endcase
      end
   end

   for (genvar i = 0; i < MW; i++) begin : g_mask
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            mask_w[i] <= '0;
         end else if (cfg_we && cfg_addr == (A_MASK0 + 4'(i))) begin
            mask_w[i] <= cfg_wdata[MASK_WORD_W-1:0];
         end
      end
      assign chan_mask[i*MASK_WORD_W +: MASK_WORD_W] = mask_w[i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ovf_q   <= 1'b0;
         drops_q <= '0;
      end else if (status_clr) begin
         ovf_q   <= drop_evt;
         drops_q <= drop_evt ? DROP_W'(1) : '0;
      end else if (drop_evt) begin
         ovf_q <= 1'b1;
         if (drops_q != '1) drops_q <= drops_q + 1'b1;
      end
   end

   always_comb begin
      cfg_rdata = '0;
      case (cfg_addr)
         A_CTRL: begin
            cfg_rdata[CTRL_ALL_BIT]               = force_q;
            cfg_rdata[CTRL_K_LSB +: K_FIELD_W]    = k_q;
         end
         A_THRESH: cfg_rdata[THR_W-1:0] = thr_q;
         A_SETTLE: cfg_rdata[BX_W-1:0]  = settle_q;
         A_STATUS: begin
            cfg_rdata[STAT_OVF_BIT]  = ovf_q;
            cfg_rdata[DROP_W-1:0]    = drops_q;
         end
         default: begin
            for (int i = 0; i < MW; i++) begin
               if (cfg_addr == (A_MASK0 + 4'(i))) cfg_rdata = mask_w[i];
            end
         end
      endcase
   end

   assign k_eff     = (k_q < K_LO) ? K_LO : ((k_q > K_HI) ? K_HI : k_q);
   assign force_all = force_q;
   assign thr       = thr_q;
   assign settle_n  = settle_q;
   assign ovf       = ovf_q;

endmodule

// File: rtl/zsup_ped_bank.sv
module zsup_ped_bank #(
   parameter int ADC_W  = 14,
   parameter int CH_W   = 8,
   parameter int FRAC_W = 8,
   parameter int K_W    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CH_W-1:0]   ch,
   input  logic [ADC_W-1:0]  sample,
   input  logic              upd,
   input  logic [K_W-1:0]    k,
   output logic [ADC_W-1:0]  ped_int
);
   localparam int NCH   = 1 << CH_W;
   localparam int PED_W = ADC_W + FRAC_W;

   if (FRAC_W < 0 || PED_W > 62) begin : g_bad_frac
      $error("pedestal width out of range");
   end

   logic [PED_W-1:0]        ped_q [NCH];
   logic [PED_W-1:0]        cur;
   logic [PED_W-1:0]        sample_fx;
   logic signed [PED_W:0]   delta;
   logic signed [PED_W:0]   step;
   logic signed [PED_W:0]   nxt_w;
   logic                    unused_nxt_msb;

   assign cur = ped_q[ch];

   if (FRAC_W > 0) begin : g_frac
      assign sample_fx = {sample, {FRAC_W{1'b0}}};
   end else begin : g_int
      assign sample_fx = sample;
   end

   assign delta          = $signed({1'b0, sample_fx}) - $signed({1'b0, cur});
   assign step           = delta >>> k;
   assign nxt_w          = $signed({1'b0, cur}) + step;
   assign unused_nxt_msb = nxt_w[PED_W];
   assign ped_int        = cur[PED_W-1:FRAC_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NCH; i++) ped_q[i] <= '0;
      end else if (upd) begin
         ped_q[ch] <= nxt_w[PED_W-1:0];
      end
   end

endmodule

// File: rtl/zsup_fifo.sv
module zsup_fifo #(
   parameter int W     = 35,
   parameter int DEPTH = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  push_data,
   output logic          drop,
   output logic          full,
   output logic          out_valid,
   input  logic          out_ready,
   output logic [W-1:0]  out_data
);
   localparam int CW = $clog2(DEPTH + 1);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

   if (DEPTH < 2 || DEPTH > 64) begin : g_bad_depth
      $error("FIFO depth must be 2..64");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [CW-1:0] cnt_q;
   logic [PW-1:0] wr_q, rd_q, wr_nxt, rd_nxt;
   logic          pop, put;

   assign full      = (cnt_q == DEPTH_C);
   assign out_valid = (cnt_q != '0);
   assign out_data  = mem[rd_q];
   assign pop       = out_valid && out_ready;
   assign put       = push && (!full || pop);
   assign drop      = push && !put;

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_nxt = wr_q + 1'b1;
      assign rd_nxt = rd_q + 1'b1;
   end else begin : g_wrap
      assign wr_nxt = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      assign rd_nxt = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (put) mem[wr_q] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         wr_q  <= '0;
         rd_q  <= '0;
      end else begin
         if (put) wr_q <= wr_nxt;
         if (pop) rd_q <= rd_nxt;
         case ({put, pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/zsup_filter.sv
module zsup_filter
   import zsup_pkg::*;
#(
   parameter int ADC_W      = 14,
   parameter int CH_W       = 8,
   parameter int BX_W       = 12,
   parameter int FRAC_W     = 8,
   parameter int FIFO_DEPTH = 8,
   parameter int DROP_W     = 16,
   parameter int K_MIN      = 2,
   parameter int K_MAX      = 8,
   parameter int THR_RST    = 20,
   parameter int K_RST      = 4,
   parameter int SETTLE_RST = 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           train_start,
   input  logic                           train_end,
   input  logic                           s_valid,
   input  logic                           s_last,
   input  logic [CH_W-1:0]                s_chan,
   input  logic [ADC_W-1:0]               s_adc,
   input  logic                           cfg_we,
   input  logic [3:0]                     cfg_addr,
   input  logic [REG_DW-1:0]              cfg_wdata,
   output logic [REG_DW-1:0]              cfg_rdata,
   output logic                           out_valid,
   input  logic                           out_ready,
   output logic [BX_W+CH_W+ADC_W:0]       out_data
);
   localparam int NCH   = 1 << CH_W;
   localparam int OUT_W = 1 + BX_W + CH_W + ADC_W;
   localparam int THR_W = ADC_W - 1;
   localparam logic [ADC_W-1:0] AMP_MAX = {1'b0, {(ADC_W-1){1'b1}}};
   localparam logic [ADC_W-1:0] AMP_MIN = {1'b1, {(ADC_W-1){1'b0}}};

   if (ADC_W < 4 || ADC_W > 31) begin : g_bad_adc
      $error("sample width out of range");
   end
   if (CH_W < 5 || CH_W > 8) begin : g_bad_ch
      $error("channel index width must be 5..8");
   end
   if (BX_W < 2) begin : g_bad_bx
      $error("bunch number too narrow");
   end

   // configuration
   logic                  force_all;
   logic [K_FIELD_W-1:0]  k_eff;
   logic [THR_W-1:0]      thr;
   logic [BX_W-1:0]       settle_n;
   logic [NCH-1:0]        chan_mask;
   logic                  ovf;
   logic                  status_clr;
   logic                  drop_evt;

   zsup_cfg_regs #(
      .ADC_W(ADC_W), .CH_W(CH_W), .BX_W(BX_W), .DROP_W(DROP_W),
      .K_MIN(K_MIN), .K_MAX(K_MAX), .THR_RST(THR_RST), .K_RST(K_RST),
      .SETTLE_RST(SETTLE_RST)
   ) i_regs (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .drop_evt(drop_evt),
      .force_all(force_all), .k_eff(k_eff), .thr(thr),
      .settle_n(settle_n), .chan_mask(chan_mask),
      .ovf(ovf), .status_clr(status_clr)
   );

   // train sequencing: window, bunch number, settling count
   logic            in_train_q;
   logic [BX_W-1:0] bx_q;
   logic [BX_W-1:0] settle_cnt_q;
   logic            take;
   logic            settling;

   assign take     = s_valid && in_train_q;
   assign settling = settle_cnt_q < settle_n;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_train_q   <= 1'b0;
         bx_q         <= '0;
         settle_cnt_q <= '0;
      end else if (train_start) begin
         in_train_q   <= 1'b1;
         bx_q         <= '0;
         settle_cnt_q <= '0;
      end else if (train_end) begin
         in_train_q   <= 1'b0;
      end else if (take && s_last) begin
         bx_q <= bx_q + 1'b1;
         if (settle_cnt_q != '1) settle_cnt_q <= settle_cnt_q + 1'b1;
      end
   end

   // pedestal tracking
   logic [ADC_W-1:0] ped_int;
   logic             upd;

   zsup_ped_bank #(
      .ADC_W(ADC_W), .CH_W(CH_W), .FRAC_W(FRAC_W), .K_W(K_FIELD_W)
   ) i_peds (
      .clk(clk), .rst_n(rst_n), .ch(s_chan), .sample(s_adc),
      .upd(upd), .k(k_eff), .ped_int(ped_int)
   );

   // correction, saturation and decision
   logic signed [ADC_W:0] diff;
   logic [ADC_W-1:0]      amp;
   logic                  above;
   logic                  raw_sel;
   logic                  fwd;
   logic [OUT_W-1:0]      word;

   assign diff    = $signed({1'b0, s_adc}) - $signed({1'b0, ped_int});
   assign amp     = (diff[ADC_W] != diff[ADC_W-1])
                    ? (diff[ADC_W] ? AMP_MIN : AMP_MAX)
                    : diff[ADC_W-1:0];
   assign above   = $signed(amp) > $signed({1'b0, thr});
   assign raw_sel = force_all || chan_mask[s_chan];
   assign fwd     = take && (raw_sel || (above && !settling));
   assign upd     = take && (settling || !above);
   assign word    = {raw_sel, bx_q, s_chan, amp};

   // output buffering
   logic fifo_full;

   zsup_fifo #(
      .W(OUT_W), .DEPTH(FIFO_DEPTH)
   ) i_fifo (
      .clk(clk), .rst_n(rst_n), .push(fwd), .push_data(word),
      .drop(drop_evt), .full(fifo_full),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
   );

endmodule

// File: rtl/zsup_filter_chk.sv
module zsup_filter_chk #(
   parameter int OUT_W = 35,
   parameter int BX_W  = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              out_valid,
   input logic              out_ready,
   input logic [OUT_W-1:0]  out_data,
   input logic              take,
   input logic              s_last,
   input logic              train_start,
   input logic              train_end,
   input logic [BX_W-1:0]   bx_q,
   input logic              fwd,
   input logic              upd,
   input logic              raw_sel,
   input logic              settling,
   input logic              drop_evt,
   input logic              fifo_full,
   input logic              ovf,
   input logic              status_clr
);

   // R9: a stalled word is held unchanged
   a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data));

   // R10: a drop only happens against a full buffer and raises the flag
   a_r10_drop_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      drop_evt |-> fifo_full ##1 ovf);

   // R10: flag stays until the status address is written
   a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovf && !status_clr |=> ovf);

   // R6: threshold forwarding never happens in the settling window
   a_r6_settle_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      fwd && !raw_sel |-> !settling);

   // R5: a sample forwarded as a hit does not move the pedestal
   a_r5_hit_no_update: assert property (@(posedge clk) disable iff (!rst_n)
      fwd && !raw_sel |-> !upd);

   // R3: the bunch number steps by one after the last sample of a crossing
   a_r3_bx_step: assert property (@(posedge clk) disable iff (!rst_n)
      take && s_last && !train_start && !train_end |=> bx_q == $past(bx_q) + 1'b1);

endmodule

bind zsup_filter zsup_filter_chk #(.OUT_W(OUT_W), .BX_W(BX_W)) i_zsup_chk (
   .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
   .out_data(out_data), .take(take), .s_last(s_last),
   .train_start(train_start), .train_end(train_end), .bx_q(bx_q),
   .fwd(fwd), .upd(upd), .raw_sel(raw_sel), .settling(settling),
   .drop_evt(drop_evt), .fifo_full(fifo_full), .ovf(ovf),
   .status_clr(status_clr)
);

// File: tb/test_zsup_filter.sv
module test_zsup_filter;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        train_start, train_end;
   logic        s_valid, s_last;
   logic [7:0]  s_chan;
   logic [13:0] s_adc;
   logic        cfg_we;
   logic [3:0]  cfg_addr;
   logic [31:0] cfg_wdata;
   logic [31:0] cfg_rdata;
   logic        out_valid, out_ready;
   logic [34:0] out_data;

   always #4 clk = ~clk;

   zsup_filter i_zsup_filter (
      .clk(clk), .rst_n(rst_n), .train_start(train_start), .train_end(train_end),
      .s_valid(s_valid), .s_last(s_last), .s_chan(s_chan), .s_adc(s_adc),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data)
   );

   int n_chk = 0;
   int n_bad = 0;

   // reference model state
   longint     ped_m [256];
   int         bx_m, settle_cnt_m, k_m, thr_m, settle_n_m, drops_m;
   bit         in_train_m, force_m, ovf_m, hold_m;
   bit [255:0] mask_m;
   logic [34:0] exp_q [$];
   logic [34:0] got;

   task automatic chk_eq(string tag, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && out_valid && out_ready) begin
         if (exp_q.size() == 0) begin
            n_chk++;
            n_bad++;
            $display("FAIL R4 unexpected word actual=%0h expected=none", out_data);
         end else begin
            got = exp_q.pop_front();
            chk_eq("R3/R4/R8 output word", out_data, got);
         end
      end
   end

   function automatic int k_clamp(int k);
      return (k < 2) ? 2 : ((k > 8) ? 8 : k);
   endfunction

   function automatic int sat14(longint v);
      return (v > 8191) ? 8191 : ((v < -8192) ? -8192 : int'(v));
   endfunction

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic send(int ch, int adc, bit last);
      longint p;
      int amp;
      bit raw, sett, above;
      s_valid = 1'b1; s_last = last; s_chan = 8'(ch); s_adc = 14'(adc);
      if (in_train_m) begin
         p     = ped_m[ch];
         amp   = sat14(longint'(adc) - (p >>> 8));
         raw   = force_m || mask_m[ch];
         sett  = settle_cnt_m < settle_n_m;
         above = amp > thr_m;
         if (raw || (above && !sett)) begin
            if (hold_m && exp_q.size() >= 8) begin
               drops_m++;
               ovf_m = 1'b1;
            end else begin
               exp_q.push_back({raw, 12'(bx_m), 8'(ch), 14'(amp)});
            end
         end
         if (sett || !above) ped_m[ch] = p + ((longint'(adc) * 256 - p) >>> k_clamp(k_m));
         if (last) begin
            bx_m = (bx_m + 1) % 4096;
            if (settle_cnt_m < 4095) settle_cnt_m++;
         end
      end
      step();
      s_valid = 1'b0; s_last = 1'b0;
   endtask

   task automatic reg_wr(int a, logic [31:0] d);
      cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = d;
      case (a)
         0: begin force_m = d[0]; k_m = int'(d[11:8]); end
         1: thr_m = int'(d[12:0]);
         2: settle_n_m = int'(d[11:0]);
         3: begin ovf_m = 1'b0; drops_m = 0; end
         default: if (a >= 8) mask_m[(a-8)*32 +: 32] = d;
      endcase
      step();
      cfg_we = 1'b0;
   endtask

   task automatic reg_chk(string tag, int a, logic [31:0] exp);
      cfg_addr = 4'(a);
      @(negedge clk);
      chk_eq(tag, cfg_rdata, exp);
      step();
   endtask

   task automatic t_start();
      train_start = 1'b1;
      in_train_m = 1'b1; bx_m = 0; settle_cnt_m = 0;
      step();
      train_start = 1'b0;
   endtask

   task automatic t_end();
      train_end = 1'b1;
      in_train_m = 1'b0;
      step();
      train_end = 1'b0;
   endtask

   task automatic drain(string tag);
      repeat (6) step();
      chk_eq(tag, exp_q.size(), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      int base [8];
      int adc;
      logic [34:0] held;
      void'($urandom(32'd4242));
      rst_n = 1'b0; train_start = 1'b0; train_end = 1'b0;
      s_valid = 1'b0; s_last = 1'b0; s_chan = '0; s_adc = '0;
      cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; out_ready = 1'b1;
      for (int i = 0; i < 256; i++) ped_m[i] = 0;
      bx_m = 0; settle_cnt_m = 0; k_m = 4; thr_m = 20; settle_n_m = 8;
      drops_m = 0; in_train_m = 0; force_m = 0; ovf_m = 0; hold_m = 0; mask_m = '0;
      repeat (4) @(posedge clk);
      #2 rst_n = 1'b1;
      step();

      // R1 reset state
      @(negedge clk);
      chk_eq("R1 out_valid after reset", out_valid, 0);
      step();
      reg_chk("R1 control default", 0, 32'h0000_0400);
      reg_chk("R1 threshold default", 1, 32'd20);
      reg_chk("R1 settling default", 2, 32'd8);
      reg_chk("R1 status default", 3, 32'd0);
      reg_chk("R1 mask default", 9, 32'd0);

      // R11 readback
      reg_wr(1, 32'd37);
      reg_chk("R11 threshold readback", 1, 32'd37);
      reg_wr(12, 32'hA5A5_0001);
      reg_chk("R11 mask word readback", 12, 32'hA5A5_0001);
      reg_chk("R11 unmapped reads zero", 5, 32'd0);
      reg_wr(12, 32'd0);
      reg_wr(1, 32'd20);

      // R2 samples outside a train are ignored
      reg_wr(0, 32'h0000_0401);
      send(3, 900, 1);
      send(3, 900, 1);
      drain("R2 no output outside train");
      t_start();
      send(3, 100, 1);
      drain("R2 pedestal untouched outside train");
      t_end();
      send(3, 50, 1);
      drain("R2 no output after train end");

      // R4 threshold boundary and positive saturation
      reg_wr(0, 32'h0000_0800);
      reg_wr(2, 32'd0);
      t_start();
      send(40, 20, 1);
      send(40, 21, 1);
      send(40, 16383, 1);
      drain("R4 boundary and saturation");
      t_end();

      // R6 settling and R7 raw mask, negative saturation
      reg_wr(0, 32'h0000_0200);
      reg_wr(2, 32'd30);
      reg_wr(8, 32'h0000_0080);
      t_start();
      for (int x = 0; x < 30; x++) begin
         send(8, 5000, 0);
         send(7, 12000, 1);
      end
      send(7, 0, 0);
      send(8, 5001, 0);
      send(8, 9000, 1);
      drain("R6/R7 settling and raw mask");
      t_end();
      reg_wr(8, 32'd0);

      // R5 shift clamping
      reg_wr(2, 32'd0);
      reg_wr(1, 32'd8191);
      reg_wr(0, 32'h0000_0001);
      t_start();
      send(50, 400, 1);
      send(50, 400, 1);
      reg_wr(0, 32'h0000_0F01);
      send(50, 400, 1);
      send(50, 400, 1);
      drain("R5 shift clamp");
      t_end();
      reg_wr(1, 32'd20);

      // R9/R10 stall and overflow
      out_ready = 1'b0; hold_m = 1'b1;
      t_start();
      for (int i = 0; i < 11; i++) send(20 + i, 50 + i, 1);
      @(negedge clk);
      held = out_data;
      repeat (3) step();
      @(negedge clk);
      chk_eq("R9 stalled word stable", out_data, held);
      chk_eq("R9 stalled valid held", out_valid, 1);
      step();
      reg_chk("R10 overflow status", 3, {ovf_m, 15'd0, 16'(drops_m)});
      out_ready = 1'b1; hold_m = 1'b0;
      repeat (12) step();
      chk_eq("R9 order after stall", exp_q.size(), 0);
      reg_chk("R10 flag sticky", 3, 32'h8000_0003);
      reg_wr(3, 32'd0);
      reg_chk("R10 status cleared", 3, 32'd0);
      t_end();
      reg_wr(0, 32'h0000_0300);

      // random trains with drifting baselines
      reg_wr(2, 32'd40);
      reg_wr(8, 32'h0000_0004);
      for (int c = 0; c < 8; c++) base[c] = 600 + c * 150;
      for (int t = 0; t < 4; t++) begin
         t_start();
         for (int x = 0; x < 120; x++) begin
            for (int c = 0; c < 8; c++) begin
               adc = base[c] + int'($urandom_range(0, 10)) - 5;
               if ($urandom_range(0, 15) == 0) adc += int'($urandom_range(30, 3000));
               if (adc > 16383) adc = 16383;
               send(c, adc, c == 7);
            end
            if ($urandom_range(0, 3) == 0) step();
         end
         t_end();
         send(1, 7000, 1);
         for (int c = 0; c < 8; c++) base[c] += int'($urandom_range(0, 40)) - 20;
         drain("R3/R4/R5 random train");
      end

      drain("R9 all words delivered");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule